// File: doc/BRIEF.md
# Quadrature Position Counter with One-Shot Zero Latch

This block keeps a position count for a rotary or linear encoder. Inputs A and B are decoded as quadrature signals, and every edge of either one moves the count by one, up or down. The third input, C, is the zero-mark pulse. The count and all of its flags sit in one clock domain. The three encoder inputs are asynchronous, so each one passes through a synchroniser before it is decoded.

A controller talks to the block through a command byte and a preset word, and it reads back a status byte and a data word.

- **Preset load.** A rising edge on the load command copies the preset word into the count. An acknowledge bit stays up until the command bit is lowered.
- **Zero-point latch.** When the latch is armed, the first rising edge of C captures the count. After that, C has no effect until the controller disarms the latch, sees the status bit drop, and arms it again.
- **Wrap flags.** Two sticky flags record a wrap upward or downward. Each flag clears only when the count later crosses a point one third or two thirds of the way through the range.
- **Feature word.** One feature bit swaps the wrap flags for the raw A, B and C levels. Another feature bit turns the latch off.

Top module: `quad_pos_counter`

## Requirements
- R1: Status bit 7 equals command bit 7 as it was at the previous clock edge. While command bit 7 is 1, a preset load never happens and the latch is held disarmed. Status bits 6 and 1 always read 0.
- R2: A rising edge of command bit 2, seen while command bit 7 is 0, loads the preset word into the count. At the clock edge that sees the rising edge, the data word takes the preset value and status bit 2 becomes 1. Status bit 2 drops to 0 at the first edge at which command bit 2 is seen low.
- R3: A is the most significant bit of the phase value {A,B}. The phase sequence 00, 10, 11, 01, 00 counts up by one per step, and the reverse sequence counts down by one per step. A change of both bits at once leaves the count as it is. An input change made before clock edge k reaches the count at edge k+2. The count wraps modulo 65536.
- R4: Command bit 0 set (with bit 7 at 0 and feature bit 15 at 0) arms the latch. The first synchronised rising edge of C then stores the current count and sets status bit 0. Later C edges change nothing while bit 0 stays set.
- R5: Status bit 0 clears at the first edge that sees command bit 0 low. Setting bit 0 again re-arms the latch, and the next C edge captures the new count.
- R6: Status bit 4 (overflow) sets on a step from 65535 to 0, which also clears status bit 3. It clears on an up step from 21845 to 21846.
- R7: Status bit 3 (underflow) sets on a step from 0 to 65535, which also clears status bit 4. It clears on a down step from 43690 to 43689.
- R8: When feature bit 0 is 1, status bits 5, 4 and 3 show the synchronised levels of A, B and C, in that order. When feature bit 0 is 0, status bit 5 reads 0.
- R9: When feature bit 15 is 1, no capture happens, status bit 0 reads 0 and the data word shows the running count.
- R10: While status bit 0 is 1, the data word shows the latched value. At all other times it shows the count.
- R11: A preset load takes effect over a count step arriving at the same edge, and that step is lost. A preset load leaves both wrap flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlByte | input | 8 | Command byte: bit 7 mode, bit 2 load, bit 0 latch arm |
| presetWord | input | 16 | Value loaded into the count |
| featureWord | input | 16 | Bit 0 selects the raw-level status layout; bit 15 disables the latch |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| encC | input | 1 | Zero-mark input, asynchronous |
| statusByte | output | 8 | Status byte |
| dataWord | output | 16 | Count, or the latched value while a latch is valid |

## Verification
The hardest case to reach from the ports is a preset load and a count step landing on the same clock edge. The step arrives two edges after the encoder input changes, but the load takes effect at the first edge. The bench therefore changes the phase inputs, waits exactly two edges, and only then raises the load bit, so that both reach the count together. The flag hysteresis takes long walks through the count; to avoid them, the bench presets the count to just below each wrap or threshold point and steps across it. The re-arm handshake is run in full: disarm, watch status bit 0 fall, re-arm, then pulse C.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int LVL_W = 3;  // A, B, C

  // Strobes and levels handed from control to datapath each cycle.
  typedef struct packed {
    logic             stepUp;
    logic             stepDown;
    logic             load;
    logic             presetHeld;
    logic             arm;
    logic             cRise;
    logic             regMode;
    logic [LVL_W-1:0] level;  // [2]=A [1]=B [0]=C, synchronised
  } qpc_stb_t;
endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  ctrlByte,
  input  logic        latchOff,
  input  logic        encA,
  input  logic        encB,
  input  logic        encC,
  output qpc_stb_t    stb
);
  localparam int IA = LVL_W - 1;
  localparam int IB = LVL_W - 2;
  localparam int IC = 0;

  logic [LVL_W-1:0] syncPipe [SYNC_LEN];
  logic [LVL_W-1:0] prevLvl;
  logic [LVL_W-1:0] curLvl;
  logic             ctrlPrev2;
  logic             moveEn;
  logic             unusedBits;

  assign unusedBits = ^{ctrlByte[6:3], ctrlByte[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_LEN; i++) syncPipe[i] <= '0;
      prevLvl   <= '0;
      ctrlPrev2 <= 1'b0;
    end else begin
      syncPipe[0] <= {encA, encB, encC};
      for (int i = 1; i < SYNC_LEN; i++) syncPipe[i] <= syncPipe[i-1];
      prevLvl   <= syncPipe[SYNC_LEN-1];
      ctrlPrev2 <= ctrlByte[2];
    end
  end

  assign curLvl = syncPipe[SYNC_LEN-1];
  assign moveEn = (curLvl[IA] ^ prevLvl[IA]) ^ (curLvl[IB] ^ prevLvl[IB]);

  always_comb begin
    stb            = '0;
    stb.stepUp     = moveEn & (curLvl[IA] ^ prevLvl[IB]);
    stb.stepDown   = moveEn & ~(curLvl[IA] ^ prevLvl[IB]);
    stb.load       = ctrlByte[2] & ~ctrlPrev2 & ~ctrlByte[7];
    stb.presetHeld = ctrlByte[2];
    stb.arm        = ctrlByte[0] & ~ctrlByte[7] & ~latchOff;
    stb.cRise      = curLvl[IC] & ~prevLvl[IC];
    stb.regMode    = ctrlByte[7];
    stb.level      = curLvl;
  end

  AST_LOAD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !stb.load);  // R2
  AST_C_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    stb.cRise |=> !stb.cRise);  // R4
endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpc_stb_t         stb,
  input  logic [CNT_W-1:0] presetWord,
  input  logic             altStatus,
  output logic [7:0]       statusByte,
  output logic [CNT_W-1:0] dataWord
);
  localparam longint      SPAN_MAX   = (longint'(1) << CNT_W) - 1;
  localparam logic [CNT_W-1:0] CNT_TOP    = '1;
  localparam logic [CNT_W-1:0] CNT_THIRD  = CNT_W'(SPAN_MAX / 3);
  localparam logic [CNT_W-1:0] CNT_TWO_TH = CNT_W'(2 * (SPAN_MAX / 3));

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] latchVal;
  logic             latchValid;
  logic             ovfFlag;
  logic             unfFlag;
  logic             loadAck;
  logic             regModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (stb.load) begin
      count <= presetWord;
    end else if (stb.stepUp) begin
      count <= count + 1'b1;
      if (count == CNT_TOP) begin
        ovfFlag <= 1'b1;
        unfFlag <= 1'b0;
      end else if (count == CNT_THIRD) begin
        ovfFlag <= 1'b0;
      end
    end else if (stb.stepDown) begin
      count <= count - 1'b1;
      if (count == '0) begin
        unfFlag <= 1'b1;
        ovfFlag <= 1'b0;
      end else if (count == CNT_TWO_TH) begin
        unfFlag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchVal   <= '0;
      latchValid <= 1'b0;
    end else if (!stb.arm) begin
      latchValid <= 1'b0;
    end else if (stb.cRise && !latchValid) begin
      latchValid <= 1'b1;
      latchVal   <= count;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadAck  <= 1'b0;
      regModeQ <= 1'b0;
    end else begin
      regModeQ <= stb.regMode;
      if (stb.load) loadAck <= 1'b1;
      else if (!stb.presetHeld) loadAck <= 1'b0;
    end
  end

  always_comb begin
    statusByte    = '0;
    statusByte[7] = regModeQ;
    statusByte[2] = loadAck;
    statusByte[0] = latchValid;
    if (altStatus) statusByte[5:3] = stb.level;
    else statusByte[4:3] = {ovfFlag, unfFlag};
  end

  assign dataWord = latchValid ? latchVal : count;

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepUp && !stb.load && count == CNT_TOP) |=> (ovfFlag && !unfFlag && count == '0));  // R6
  AST_UNF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepDown && !stb.load && count == '0) |=> (unfFlag && !ovfFlag && count == CNT_TOP));  // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));  // R6
  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (count == $past(presetWord) && $stable(ovfFlag) && $stable(unfFlag)));  // R11
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (latchValid && stb.arm) |=> (latchValid && $stable(latchVal)));  // R4
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ctrlByte,
  input  logic [CNT_W-1:0] presetWord,
  input  logic [15:0]      featureWord,
  input  logic             encA,
  input  logic             encB,
  input  logic             encC,
  output logic [7:0]       statusByte,
  output logic [CNT_W-1:0] dataWord
);
  qpc_stb_t stb;
  logic     unusedFeat;

  assign unusedFeat = ^featureWord[14:1];

  qpc_ctrl #(.SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .latchOff(featureWord[15]),
    .encA(encA), .encB(encB), .encC(encC), .stb(stb)
  );

  qpc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .presetWord(presetWord),
    .altStatus(featureWord[0]), .statusByte(statusByte), .dataWord(dataWord)
  );
endmodule

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ctrlByte = '0;
  logic [15:0] presetWord = '0;
  logic [15:0] featureWord = '0;
  logic        encA = 1'b0, encB = 1'b0, encC = 1'b0;
  logic [7:0]  statusByte;
  logic [15:0] dataWord;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int phaseIdx = 0;
  bit done = 0;

  quad_pos_counter u_quad_pos_counter (
    .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .presetWord(presetWord),
    .featureWord(featureWord), .encA(encA), .encB(encB), .encC(encC),
    .statusByte(statusByte), .dataWord(dataWord)
  );

  always #5 clk = ~clk;

  // behavioural reference
  bit mS1[3], mS2[3], mPrev[3];
  bit mCtrlPrev2, mOvf, mUnf, mAck, mLatchV, mReg7;
  int mCount, mLatch;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mS1 = '{0,0,0}; mS2 = '{0,0,0}; mPrev = '{0,0,0};
      mCtrlPrev2 = 0; mOvf = 0; mUnf = 0; mAck = 0; mLatchV = 0; mReg7 = 0;
      mCount = 0; mLatch = 0;
    end else begin
      bit en, up, cR, ld, arm;
      en  = (mS2[0] ^ mPrev[0]) ^ (mS2[1] ^ mPrev[1]);
      up  = mS2[0] ^ mPrev[1];
      cR  = mS2[2] && !mPrev[2];
      ld  = ctrlByte[2] && !mCtrlPrev2 && !ctrlByte[7];
      arm = ctrlByte[0] && !ctrlByte[7] && !featureWord[15];
      if (!arm) mLatchV = 0;
      else if (cR && !mLatchV) begin mLatchV = 1; mLatch = mCount; end
      if (ld) mCount = presetWord;
      else if (en && up) begin
        if (mCount == 65535) begin mOvf = 1; mUnf = 0; end
        else if (mCount == 21845) mOvf = 0;
        mCount = (mCount + 1) % 65536;
      end else if (en) begin
        if (mCount == 0) begin mUnf = 1; mOvf = 0; end
        else if (mCount == 43690) mUnf = 0;
        mCount = (mCount + 65535) % 65536;
      end
      if (ld) mAck = 1; else if (!ctrlByte[2]) mAck = 0;
      mReg7 = ctrlByte[7];
      mCtrlPrev2 = ctrlByte[2];
      mPrev = mS2; mS2 = mS1;
      mS1[0] = encA; mS1[1] = encB; mS1[2] = encC;
    end
    #3;
    if (rstN && !done) begin
      check("R1 mode echo", statusByte[7], mReg7);
      check("R1 reserved", {statusByte[6], statusByte[1]}, 0);
      check("R2 load ack", statusByte[2], mAck);
      check(featureWord[15] ? "R9 latch off" : "R4 latch status", statusByte[0], mLatchV);
      check(mLatchV ? "R10 latched data" : "R3 count data", dataWord, mLatchV ? mLatch : mCount);
      if (featureWord[0])
        check("R8 raw levels", statusByte[5:3], {mS2[0], mS2[1], mS2[2]});
      else begin
        check("R8 bit5 idle", statusByte[5], 0);
        check("R6 overflow", statusByte[4], mOvf);
        check("R7 underflow", statusByte[3], mUnf);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic encMove(int dir, int settle);
    phaseIdx = (phaseIdx + dir + 4) % 4;
    case (phaseIdx)
      0: {encA, encB} = 2'b00;
      1: {encA, encB} = 2'b10;
      2: {encA, encB} = 2'b11;
      default: {encA, encB} = 2'b01;
    endcase
    tick(settle);
  endtask

  task automatic walk(int dir, int n);
    for (int i = 0; i < n; i++) encMove(dir, 2);
    tick(3);
  endtask

  task automatic pulseLoad(int val);
    presetWord = val[15:0];
    ctrlByte[2] = 1'b1;
    tick(1);
    check("R2 loaded value", dataWord, val);
    check("R2 ack set", statusByte[2], 1);
    tick(1);
    ctrlByte[2] = 1'b0;
    tick(1);
    check("R2 ack cleared", statusByte[2], 0);
  endtask

  task automatic pulseC();
    encC = 1'b1; tick(4);
    encC = 1'b0; tick(4);
  endtask

  initial begin
    tick(2);
    check("R1 reset status", statusByte, 0);
    check("R3 reset count", dataWord, 0);
    rstN = 1'b1;
    tick(2);

    walk(1, 5);
    check("R3 up count", dataWord, 5);
    walk(-1, 7);
    check("R3 down wrap", dataWord, 65534);
    check("R7 underflow set", statusByte[3], 1);
    walk(1, 2);
    check("R6 overflow wrap", dataWord, 0);
    check("R6 overflow set", statusByte[4], 1);
    check("R7 cleared by overflow", statusByte[3], 0);

    {encA, encB} = 2'b11; tick(5);
    check("R3 double change ignored", dataWord, 0);
    {encA, encB} = 2'b00; tick(5);
    check("R3 double change back", dataWord, 0);

    pulseLoad(21844);
    check("R11 flags kept", statusByte[4], 1);
    walk(1, 1);
    check("R6 still set at 21845", statusByte[4], 1);
    walk(1, 1);
    check("R6 cleared past third", statusByte[4], 0);

    pulseLoad(1);
    walk(-1, 2);
    check("R7 set", statusByte[3], 1);
    pulseLoad(43691);
    check("R11 underflow kept", statusByte[3], 1);
    walk(-1, 1);
    check("R7 still set at 43690", statusByte[3], 1);
    walk(-1, 1);
    check("R7 cleared past two thirds", statusByte[3], 0);

    pulseLoad(100);
    ctrlByte[0] = 1'b1; tick(2);
    pulseC();
    check("R4 captured", statusByte[0], 1);
    check("R10 latched value", dataWord, 100);
    walk(1, 3);
    check("R10 latch shown while count moves", dataWord, 100);
    pulseC();
    check("R4 second pulse ignored", dataWord, 100);
    ctrlByte[0] = 1'b0; tick(1);
    check("R5 reset acknowledged", statusByte[0], 0);
    check("R10 count after release", dataWord, 103);
    ctrlByte[0] = 1'b1; tick(1);
    walk(1, 1);
    pulseC();
    check("R5 re-armed capture", dataWord, 104);
    check("R5 re-armed status", statusByte[0], 1);

    ctrlByte[0] = 1'b0; tick(1);
    featureWord[15] = 1'b1; ctrlByte[0] = 1'b1; tick(1);
    walk(1, 1);
    pulseC();
    check("R9 no capture", statusByte[0], 0);
    check("R9 live count", dataWord, 105);
    featureWord[15] = 1'b0; ctrlByte[0] = 1'b0; tick(1);

    featureWord[0] = 1'b1;
    encC = 1'b1; tick(4);
    check("R8 levels A B C", statusByte[5:3], {encA, encB, 1'b1});
    encC = 1'b0; tick(4);
    check("R8 C low", statusByte[3], 0);
    featureWord[0] = 1'b0; tick(1);

    ctrlByte = 8'h84; presetWord = 16'd5; tick(2);
    check("R1 mode echoed", statusByte[7], 1);
    check("R1 load blocked", dataWord, 105);
    ctrlByte = 8'h00; tick(2);

    encMove(1, 2);
    presetWord = 16'd777; ctrlByte[2] = 1'b1;
    tick(1);
    check("R11 load beats step", dataWord, 777);
    tick(3);
    check("R11 step dropped", dataWord, 777);
    ctrlByte[2] = 1'b0; tick(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule